// File: doc/BRIEF.md
# Serial Quad DAC Setting Interface

This block is a three-wire serial slave that holds four 8-bit DAC setting registers and presents them as one parallel bus to the converters. A host raises chip select and clocks in a frame of eleven bits on the data input. The frame is a 1 start bit, two address bits sent low bit first, and eight data bits sent LSB first. The serial clock is the block clock, so every sampling point is a rising edge of `clk`.

While the data bits arrive, the addressed register's current setting leaves on the serial output, one bit per clock. Every transfer is therefore also a read. The data is moved into a separate shift register, so the live setting does not change while the frame is in progress. The new value is applied one clock after the last data bit. The completion pulse tells the program sequencer that a frame has finished. If the program request is high at that edge, the value is also copied into a nonvolatile shadow array.

If chip select falls after the address is known but before the apply edge, the addressed register is reloaded from the shadow array. This gives a read-only cycle that leaves the output unchanged. The serial output has a separate data line and pad enable, and the enable is active only while chip select is high.

Top module: `quad_dac_serial`

## Requirements
- R1: `doOe` is low in every cycle where `csIn` is low, and high while `csIn` is high.
- R2: While `csIn` is high and no frame is open, 0 bits on `diIn` are ignored. The first 1 sampled opens a frame.
- R3: The two bits after the start bit are A0 then A1. A1:A0 = 00, 01, 10, 11 selects setting 0, 1, 2, 3, which is bits [8k+7:8k] of `dacVal`. Only the selected setting may change.
- R4: `doData` is 0 while the address is being received. While data bit k (k = 0..7) is driven on `diIn`, `doData` shows bit k of the addressed setting as it stood before the frame.
- R5: The data bits are D0 first through D7 last. `dacVal` keeps its old value after the edge that samples D7. The next rising edge (the 12th clock of the frame) loads the new value, and `frameDone` is high for exactly the one cycle after that edge.
- R6: A start bit on the 13th clock, right after the apply edge, opens the next frame.
- R7: If `csIn` is sampled low after the address is complete and before the apply edge, the addressed setting is reloaded from the shadow array, and `frameDone` stays low.
- R8: If `progIn` is high at the apply edge, the shadow entry takes the new value. If it is low, the shadow entry is left alone, and a later read-only cycle reverts the setting to the older stored value.
- R9: After reset every setting and every shadow entry holds `RESET_VAL` (0x80), and `frameDone` is low.
- R10: Sampling `csIn` low discards a partly received header, so a full frame sent afterwards is decoded from its own start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; data is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Chip select, active high |
| diIn | input | 1 | Serial data input |
| progIn | input | 1 | Request to store the frame's value in the shadow array |
| doData | output | 1 | Serial read-back data |
| doOe | output | 1 | Pad enable for the serial output (high impedance when low) |
| frameDone | output | 1 | One-cycle pulse after a frame is applied |
| dacVal | output | 32 | Four settings, setting k in bits [8k+7:8k] |

## Verification
The checker module tests four properties on every cycle. The completion pulse lasts a single cycle. The pulse is raised only for a frame that was applied with chip select high. The bit counter is back at idle when the pulse is raised. The settings bus changes only on an apply edge or on an edge with chip select low.

Some behaviour can only be shown by the bench scenarios, which compare against a model of the settings and the shadow array:
- the read-back bit order and its alignment with the incoming data,
- the exact apply cycle,
- back-to-back frames,
- decoding after leading zeros and after a broken header,
- the value restored by read-only cycles cut off after each possible number of data bits.

// File: rtl/quad_dac_pkg.sv
`timescale 1ns/1ps
package quad_dac_pkg;
  // strobes from the frame controller to the setting datapath
  typedef struct packed {
    logic loadShift;  // copy addressed setting into the shift register
    logic shiftEn;    // shift one data bit in, one read-back bit out
    logic commit;     // write the shift register into the addressed setting
    logic restore;    // reload addressed setting from the shadow array
  } dacStrobe_t;
endpackage

// File: rtl/dac_frame_ctrl.sv
`timescale 1ns/1ps
module dac_frame_ctrl
  import quad_dac_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              diIn,
  input  logic              progIn,
  output dacStrobe_t        stb,
  output logic              progWr,
  output logic [ADDR_W-1:0] addr,
  output logic              dataWin,
  output logic [CNT_W-1:0]  frameCnt,
  output logic              frameDone
);
  localparam logic [CNT_W-1:0] ADDR_END  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(ADDR_W + DATA_W);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(ADDR_W + DATA_W + 1);

  logic [ADDR_W-1:0] addrR;
  logic [ADDR_W-1:0] addrNext;
  logic              inAddr;

  // merge the bit arriving now into the address being assembled
  always_comb begin
    addrNext = addrR;
    inAddr   = 1'b0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (frameCnt == CNT_W'(i + 1)) begin
        addrNext[i] = diIn;
        inAddr      = 1'b1;
      end
    end
  end

  assign dataWin       = csIn && (frameCnt > ADDR_END) && (frameCnt <= DATA_END);
  assign stb.loadShift = csIn && (frameCnt == ADDR_END);
  assign stb.shiftEn   = dataWin;
  assign stb.commit    = csIn && (frameCnt == FRAME_END);
  assign stb.restore   = !csIn && (frameCnt > ADDR_END);
  assign progWr        = stb.commit && progIn;
  assign addr          = addrNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt  <= '0;
      addrR     <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= stb.commit;
      if (!csIn) begin
        frameCnt <= '0;
      end else if (frameCnt == '0) begin
        if (diIn) frameCnt <= CNT_W'(1);
      end else if (frameCnt == FRAME_END) begin
        frameCnt <= '0;
      end else begin
        frameCnt <= frameCnt + CNT_W'(1);
      end
      if (csIn && inAddr) addrR <= addrNext;
    end
  end
endmodule

// File: rtl/dac_nv_store.sv
`timescale 1ns/1ps
module dac_nv_store #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter logic [DATA_W-1:0] RESET_VAL = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] cells [NUM_REGS];

  assign rdData = cells[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) cells[i] <= RESET_VAL;
    end else if (wrEn) begin
      cells[addr] <= wrData;
    end
  end
endmodule

// File: rtl/dac_shift_path.sv
`timescale 1ns/1ps
module dac_shift_path
  import quad_dac_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter logic [DATA_W-1:0] RESET_VAL = 'h80
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       diIn,
  input  dacStrobe_t                 stb,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       dataWin,
  input  logic [DATA_W-1:0]          nvRd,
  output logic                       doBit,
  output logic [DATA_W-1:0]          shiftOut,
  output logic [NUM_REGS*DATA_W-1:0] dacVal
);
  logic [DATA_W-1:0] setting [NUM_REGS];
  logic [DATA_W-1:0] shiftR;

  assign doBit    = dataWin & shiftR[0];
  assign shiftOut = shiftR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftR <= '0;
    end else if (stb.loadShift) begin
      shiftR <= setting[addr];
    end else if (stb.shiftEn) begin
      shiftR <= {diIn, shiftR[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) setting[i] <= RESET_VAL;
    end else if (stb.commit) begin
      setting[addr] <= shiftR;
    end else if (stb.restore) begin
      setting[addr] <= nvRd;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign dacVal[g*DATA_W +: DATA_W] = setting[g];
  end
endmodule

// File: rtl/quad_dac_serial.sv
`timescale 1ns/1ps
module quad_dac_serial
  import quad_dac_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = 'h80
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csIn,
  input  logic                       diIn,
  input  logic                       progIn,
  output logic                       doData,
  output logic                       doOe,
  output logic                       frameDone,
  output logic [NUM_REGS*DATA_W-1:0] dacVal
);
  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam int CNT_W  = $clog2(ADDR_W + DATA_W + 2);

  dacStrobe_t        stb;
  logic              progWr;
  logic [ADDR_W-1:0] addr;
  logic              dataWin;
  logic [CNT_W-1:0]  frameCnt;
  logic [DATA_W-1:0] nvRd;
  logic [DATA_W-1:0] shiftOut;

  assign doOe = csIn;

  dac_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .diIn(diIn), .progIn(progIn),
    .stb(stb), .progWr(progWr), .addr(addr), .dataWin(dataWin),
    .frameCnt(frameCnt), .frameDone(frameDone)
  );

  dac_shift_path #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                   .RESET_VAL(RESET_VAL)) u_path (
    .clk(clk), .rstN(rstN), .diIn(diIn), .stb(stb), .addr(addr),
    .dataWin(dataWin), .nvRd(nvRd), .doBit(doData), .shiftOut(shiftOut),
    .dacVal(dacVal)
  );

  dac_nv_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .RESET_VAL(RESET_VAL)) u_nv (
    .clk(clk), .rstN(rstN), .wrEn(progWr), .addr(addr),
    .wrData(shiftOut), .rdData(nvRd)
  );
endmodule

// File: rtl/quad_dac_serial_chk.sv
`timescale 1ns/1ps
module quad_dac_serial_chk #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       csIn,
  input logic                       frameDone,
  input logic [NUM_REGS*DATA_W-1:0] dacVal,
  input logic [CNT_W-1:0]           frameCnt
);
  // R5: completion pulse is a single cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R7: a frame is only applied when chip select was high at the apply edge
  a_r7_done_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(csIn));

  // R6: the controller is idle again when the pulse is raised
  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (frameCnt == '0));

  // R5 / R7: settings move only on an apply edge or a chip-select-low edge
  a_r5_dac_change_cause: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacVal) |-> (frameDone || !$past(csIn)));
endmodule

bind quad_dac_serial quad_dac_serial_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .frameDone(frameDone),
  .dacVal(dacVal), .frameCnt(frameCnt)
);

// File: tb/quad_dac_serial_tb.sv
`timescale 1ns/1ps
module quad_dac_serial_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csIn = 1'b0;
  logic        diIn = 1'b0;
  logic        progIn = 1'b0;
  logic        doData;
  logic        doOe;
  logic        frameDone;
  logic [31:0] dacVal;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [7:0] mReg [4];
  logic [7:0] mNv  [4];

  always #4 clk = ~clk;

  quad_dac_serial u_dut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .diIn(diIn), .progIn(progIn),
    .doData(doData), .doOe(doOe), .frameDone(frameDone), .dacVal(dacVal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    for (int a = 0; a < 4; a++) check(req, {24'd0, dacVal[a*8 +: 8]}, {24'd0, mReg[a]});
  endtask

  // abortAt < 0: full frame; otherwise chip select drops after abortAt data bits
  task automatic doFrame(input int a, input logic [7:0] d, input bit prog,
                         input int abortAt, input bit startNow);
    if (!startNow) @(negedge clk);
    csIn = 1'b1; diIn = 1'b1; progIn = prog;
    @(posedge clk);
    @(negedge clk); diIn = a[0];
    #1 check("R4 addr phase", {31'd0, doData}, 32'd0);
    check("R1 oe high", {31'd0, doOe}, 32'd1);
    @(posedge clk);
    @(negedge clk); diIn = a[1];
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      if (abortAt == k) break;
      @(negedge clk); diIn = d[k];
      #1 check("R4 readback bit", {31'd0, doData}, {31'd0, mReg[a][k]});
      @(posedge clk);
    end
    if (abortAt >= 0) begin
      @(negedge clk); csIn = 1'b0; diIn = 1'b0;
      #1 check("R1 oe low", {31'd0, doOe}, 32'd0);
      @(posedge clk);
      @(negedge clk); #1;
      mReg[a] = mNv[a];
      checkAll("R7 restore");
      check("R7 no done", {31'd0, frameDone}, 32'd0);
    end else begin
      @(negedge clk); diIn = 1'b0;
      #1 check("R5 not yet applied", {24'd0, dacVal[a*8 +: 8]}, {24'd0, mReg[a]});
      @(posedge clk);
      @(negedge clk); #1;
      mReg[a] = d;
      if (prog) mNv[a] = d;
      check("R5 done pulse", {31'd0, frameDone}, 32'd1);
      checkAll("R3 R5 applied");
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 4; a++) begin mReg[a] = 8'h80; mNv[a] = 8'h80; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1 checkAll("R9 reset");
    check("R9 done low", {31'd0, frameDone}, 32'd0);
    check("R1 oe low at reset", {31'd0, doOe}, 32'd0);

    // R3 R5 R8: sweep addresses and values, each followed by a read-only cycle
    for (int a = 0; a < 4; a++) begin
      for (int i = 0; i < 6; i++) begin
        logic [7:0] d;
        d = 8'((a * 67 + i * 53 + 5) & 255);
        doFrame(a, d, i[0], -1, 1'b0);
        @(negedge clk); csIn = 1'b0;
        doFrame(a, ~d, 1'b0, (a + i * 3) % 9, 1'b0);   // R7 R8
      end
    end

    // R6: back-to-back frames, start bit on the 13th clock
    doFrame(2, 8'h3C, 1'b1, -1, 1'b0);
    doFrame(1, 8'hA5, 1'b1, -1, 1'b1);
    doFrame(3, 8'h01, 1'b0, -1, 1'b1);
    @(negedge clk); csIn = 1'b0;
    doFrame(3, 8'hFF, 1'b0, 8, 1'b0);   // R8: unstored write reverts

    // R2: leading zeros ignored
    @(negedge clk); csIn = 1'b1; diIn = 1'b0; progIn = 1'b0;
    repeat (4) @(posedge clk);
    #1 checkAll("R2 zeros idle");
    doFrame(0, 8'h96, 1'b1, -1, 1'b0);

    // R10: broken header then a clean frame
    @(negedge clk); csIn = 1'b0;
    @(negedge clk); csIn = 1'b1; diIn = 1'b1;
    @(negedge clk); diIn = 1'b1;
    @(negedge clk); csIn = 1'b0; diIn = 1'b0;
    @(negedge clk); #1 checkAll("R10 header dropped");
    doFrame(1, 8'h5A, 1'b0, -1, 1'b0);
    @(negedge clk); csIn = 1'b0;
    #1 check("R1 oe low after frame", {31'd0, doOe}, 32'd0);
    checkAll("R10 final");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule